// File: doc/BRIEF.md
# Configuration Status Word with Sticky Error Flags

This block holds the 16-bit status word of a PCI-style configuration header, found at byte offset 06h. Six of its bits are error flags. Single-cycle pulses from the bus interface and the error logic set these flags. Once set, a flag stays at 1 until software writes a 1 to that bit position. The remaining bits are either fixed capability and timing codes, a live copy of the function's interrupt request, or reserved zeros.

The block has a plain configuration access port made of a byte offset, two byte enables, write data and a combinational read path. It takes three enable bits from the command register, which sits outside the block: parity-error response, system-error enable and interrupt disable. Its only other output is the gated interrupt pin. The interrupt-disable bit acts on the pin alone and never on the status bit that shows the request.

Top module: `cfgstat_reg`

## Requirements
- R1: After reset, a read at offset 06h returns 0210h while the interrupt request is low.
- R2: The read data is 0000h when the read strobe is low or the offset is not 06h.
- R3: Each of the following events sets its bit one cycle later: an address parity error or a data parity error sets bit 15, a master abort sets bit 13, a received target abort sets bit 12, and a target abort issued by this device sets bit 11.
- R4: Bit 14 sets only when a system-error signalling pulse arrives while the system-error enable is 1.
- R5: Bit 8 sets only when three conditions hold in the same cycle: a parity-error pulse from any agent, this device owning the data phase as master, and the parity-error response enable set to 1.
- R6: A write at offset 06h clears each sticky bit whose written data bit is 1 and whose byte lane is enabled. Byte enable bit 0 covers data bits 7:0 and byte enable bit 1 covers data bits 15:8. A sticky bit written with 0 keeps its value. A write to any other offset changes nothing.
- R7: When a set event and a write-1-to-clear reach the same bit in the same cycle, the bit ends up at 1.
- R8: Bits 10:9 always read 01b, bits 7:5 read 0, bit 4 reads 1 and bits 2:0 read 0, whatever data was written.
- R9: Bit 3 equals the interrupt request input in the same cycle, for either value of the interrupt-disable input.
- R10: The interrupt pin is 1 exactly when the interrupt request is 1 and interrupt disable is 0.
- R11: A sticky bit that is set keeps its value through idle cycles with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, release synchronous to clk |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_offset | input | 8 | Configuration byte offset |
| cfg_be | input | 2 | Byte enables for the two data lanes |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data, combinational |
| ev_addr_par | input | 1 | Pulse: address parity error detected |
| ev_data_par | input | 1 | Pulse: data parity error detected |
| ev_serr_sent | input | 1 | Pulse: system error signalled |
| ev_mst_abort | input | 1 | Pulse: own master cycle ended in master abort |
| ev_tgt_abort_rcvd | input | 1 | Pulse: own master cycle ended in target abort |
| ev_tgt_abort_sent | input | 1 | Pulse: this target ended a transaction with target abort |
| ev_perr_seen | input | 1 | Pulse: parity-error line asserted by any agent |
| bus_master_phase | input | 1 | This device is master for the current data phase |
| cmd_perr_en | input | 1 | Parity-error response enable from the command register |
| cmd_serr_en | input | 1 | System-error enable from the command register |
| cmd_int_dis | input | 1 | Interrupt disable from the command register |
| irq_req | input | 1 | Raw interrupt request of the function |
| int_pin | output | 1 | Gated interrupt output, active high |

## Verification
The assertions assume that every event input is a clean, known level at each clock edge. They also assume that the command enables and the master-phase qualifier are already valid in the same cycle as the pulse they qualify, since the block samples all of them together. The stimulus changes every input only on the falling edge, so each input holds steady across the rising edge. It pulses each event for exactly one cycle, and it sweeps every combination of the qualifiers while the event pulse is high. Writes use only the two enables of a 16-bit lane pair and offsets that are aligned to that pair.

// File: rtl/cfgstat_pkg.sv
package cfgstat_pkg;

  localparam int unsigned STAT_W = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = STAT_W / LANE_W;

  // bit positions whose meaning is fixed by the configuration header layout
  localparam int unsigned B_PAR_DET   = 15;
  localparam int unsigned B_SERR_SIG  = 14;
  localparam int unsigned B_MABORT    = 13;
  localparam int unsigned B_TABORT_RX = 12;
  localparam int unsigned B_TABORT_TX = 11;
  localparam int unsigned B_DPAR_RPT  = 8;
  localparam int unsigned B_INT_STAT  = 3;

  localparam logic [STAT_W-1:0] STICKY_MASK =
    (STAT_W'(1) << B_PAR_DET)   | (STAT_W'(1) << B_SERR_SIG)  |
    (STAT_W'(1) << B_MABORT)    | (STAT_W'(1) << B_TABORT_RX) |
    (STAT_W'(1) << B_TABORT_TX) | (STAT_W'(1) << B_DPAR_RPT);

  // constant bits: medium select timing (01b at 10:9), capability list at 4
  localparam logic [STAT_W-1:0] FIXED_VALUE = 16'h0210;

  typedef struct packed {
    logic addr_par;
    logic data_par;
    logic serr_sent;
    logic mst_abort;
    logic tgt_abort_rcvd;
    logic tgt_abort_sent;
    logic perr_seen;
    logic master_phase;
  } stat_ev_t;

  typedef struct packed {
    logic perr_en;
    logic serr_en;
  } stat_qual_t;

endpackage

// File: rtl/cfgstat_wr_decode.sv
module cfgstat_wr_decode
  import cfgstat_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h06
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] offset,
  input  logic [LANES-1:0]  be,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] clr_mask,
  output logic              rd_hit
);

  logic hit;
  logic [STAT_W-1:0] lane_mask;

  always_comb begin
    hit    = (offset == REG_OFFSET);
    rd_hit = rd_en & hit;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
  end

  always_comb begin
    clr_mask = '0;
    if (wr_en && hit) begin
      clr_mask = wdata & lane_mask & STICKY_MASK;
    end
  end

endmodule

// File: rtl/cfgstat_set_logic.sv
module cfgstat_set_logic
  import cfgstat_pkg::*;
(
  input  stat_ev_t          ev,
  input  stat_qual_t        qual,
  output logic [STAT_W-1:0] set_vec
);

  always_comb begin
    set_vec              = '0;
    set_vec[B_PAR_DET]   = ev.addr_par | ev.data_par;
    set_vec[B_SERR_SIG]  = ev.serr_sent & qual.serr_en;
    set_vec[B_MABORT]    = ev.mst_abort;
    set_vec[B_TABORT_RX] = ev.tgt_abort_rcvd;
    set_vec[B_TABORT_TX] = ev.tgt_abort_sent;
    set_vec[B_DPAR_RPT]  = ev.perr_seen & ev.master_phase & qual.perr_en;
  end

endmodule

// File: rtl/cfgstat_w1c_bit.sv
module cfgstat_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  logic en;
  logic d;

  // set has priority over a same-cycle clear
  always_comb begin
    en = set_i | clr_i;
    d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/cfgstat_reg.sv
module cfgstat_reg
  import cfgstat_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [ADDR_W-1:0] cfg_offset,
  input  logic [LANES-1:0]  cfg_be,
  input  logic [STAT_W-1:0] cfg_wdata,
  output logic [STAT_W-1:0] cfg_rdata,
  input  logic              ev_addr_par,
  input  logic              ev_data_par,
  input  logic              ev_serr_sent,
  input  logic              ev_mst_abort,
  input  logic              ev_tgt_abort_rcvd,
  input  logic              ev_tgt_abort_sent,
  input  logic              ev_perr_seen,
  input  logic              bus_master_phase,
  input  logic              cmd_perr_en,
  input  logic              cmd_serr_en,
  input  logic              cmd_int_dis,
  input  logic              irq_req,
  output logic              int_pin
);

  stat_ev_t          ev;
  stat_qual_t        qual;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_mask;
  logic [STAT_W-1:0] stat_word;
  logic              rd_hit;
  logic              unused_bits;

  always_comb begin
    ev.addr_par       = ev_addr_par;
    ev.data_par       = ev_data_par;
    ev.serr_sent      = ev_serr_sent;
    ev.mst_abort      = ev_mst_abort;
    ev.tgt_abort_rcvd = ev_tgt_abort_rcvd;
    ev.tgt_abort_sent = ev_tgt_abort_sent;
    ev.perr_seen      = ev_perr_seen;
    ev.master_phase   = bus_master_phase;
    qual.perr_en      = cmd_perr_en;
    qual.serr_en      = cmd_serr_en;
  end

  cfgstat_wr_decode #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) i_wr_decode (
    .wr_en    (cfg_wr_en),
    .rd_en    (cfg_rd_en),
    .offset   (cfg_offset),
    .be       (cfg_be),
    .wdata    (cfg_wdata),
    .clr_mask (clr_mask),
    .rd_hit   (rd_hit)
  );

  cfgstat_set_logic i_set_logic (
    .ev      (ev),
    .qual    (qual),
    .set_vec (set_vec)
  );

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      cfgstat_w1c_bit i_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[i]),
        .clr_i (clr_mask[i]),
        .q     (stat_word[i])
      );
    end else if (i == B_INT_STAT) begin : g_live
      assign stat_word[i] = irq_req;
    end else begin : g_fixed
      assign stat_word[i] = FIXED_VALUE[i];
    end
  end

  assign unused_bits = ^((set_vec | clr_mask) & ~STICKY_MASK);

  always_comb begin
    cfg_rdata = rd_hit ? stat_word : '0;
    int_pin   = irq_req & ~cmd_int_dis;
  end

endmodule

// File: rtl/cfgstat_reg_chk.sv
module cfgstat_reg_chk
  import cfgstat_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h06
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic              cfg_rd_en,
  input logic [ADDR_W-1:0] cfg_offset,
  input logic [LANES-1:0]  cfg_be,
  input logic [STAT_W-1:0] cfg_wdata,
  input logic [STAT_W-1:0] cfg_rdata,
  input logic              ev_serr_sent,
  input logic              ev_mst_abort,
  input logic              ev_perr_seen,
  input logic              bus_master_phase,
  input logic              cmd_perr_en,
  input logic              cmd_serr_en,
  input logic              irq_req,
  input logic [STAT_W-1:0] stat_word
);

  logic hi_wr;
  assign hi_wr = cfg_wr_en && (cfg_offset == REG_OFFSET) && cfg_be[1];

  // R3
  mabort_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mst_abort |=> stat_word[B_MABORT]);

  // R4
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_word[B_SERR_SIG] && !(ev_serr_sent && cmd_serr_en)) |=> !stat_word[B_SERR_SIG]);

  // R5
  dpar_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_perr_seen && bus_master_phase && cmd_perr_en) |=> stat_word[B_DPAR_RPT]);

  // R5
  dpar_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_word[B_DPAR_RPT] && !(ev_perr_seen && bus_master_phase && cmd_perr_en))
      |=> !stat_word[B_DPAR_RPT]);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mst_abort && hi_wr && cfg_wdata[B_MABORT]) |=> stat_word[B_MABORT]);

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> ((stat_word & $past(stat_word) & STICKY_MASK) == ($past(stat_word) & STICKY_MASK)));

  // R8
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_en && cfg_offset == REG_OFFSET) |-> ((cfg_rdata & 16'h06F7) == FIXED_VALUE));

  // R9
  int_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_en && cfg_offset == REG_OFFSET) |-> (cfg_rdata[B_INT_STAT] == irq_req));

endmodule

bind cfgstat_reg cfgstat_reg_chk #(
  .ADDR_W     (ADDR_W),
  .REG_OFFSET (REG_OFFSET)
) i_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_wr_en        (cfg_wr_en),
  .cfg_rd_en        (cfg_rd_en),
  .cfg_offset       (cfg_offset),
  .cfg_be           (cfg_be),
  .cfg_wdata        (cfg_wdata),
  .cfg_rdata        (cfg_rdata),
  .ev_serr_sent     (ev_serr_sent),
  .ev_mst_abort     (ev_mst_abort),
  .ev_perr_seen     (ev_perr_seen),
  .bus_master_phase (bus_master_phase),
  .cmd_perr_en      (cmd_perr_en),
  .cmd_serr_en      (cmd_serr_en),
  .irq_req          (irq_req),
  .stat_word        (stat_word)
);

// File: tb/test_cfgstat_reg.sv
`timescale 1ns/1ps
module test_cfgstat_reg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en, cfg_rd_en;
  logic [7:0]  cfg_offset;
  logic [1:0]  cfg_be;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic ev_addr_par, ev_data_par, ev_serr_sent, ev_mst_abort;
  logic ev_tgt_abort_rcvd, ev_tgt_abort_sent, ev_perr_seen, bus_master_phase;
  logic cmd_perr_en, cmd_serr_en, cmd_int_dis, irq_req;
  logic int_pin;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [15:0] FIX  = 16'h0210;
  localparam logic [15:0] STK  = 16'hF900;

  always #2 clk = ~clk;

  cfgstat_reg i_cfgstat_reg (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_offset(cfg_offset),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_addr_par(ev_addr_par), .ev_data_par(ev_data_par), .ev_serr_sent(ev_serr_sent),
    .ev_mst_abort(ev_mst_abort), .ev_tgt_abort_rcvd(ev_tgt_abort_rcvd),
    .ev_tgt_abort_sent(ev_tgt_abort_sent), .ev_perr_seen(ev_perr_seen),
    .bus_master_phase(bus_master_phase), .cmd_perr_en(cmd_perr_en),
    .cmd_serr_en(cmd_serr_en), .cmd_int_dis(cmd_int_dis), .irq_req(irq_req),
    .int_pin(int_pin)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] exp);
    cfg_rd_en = 1'b1; cfg_offset = 8'h06;
    #0.5;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] off, input logic [1:0] be, input logic [15:0] d);
    cfg_wr_en = 1'b1; cfg_offset = off; cfg_be = be; cfg_wdata = d;
    tick();
    cfg_wr_en = 1'b0; cfg_offset = 8'h06;
  endtask

  task automatic clear_all();
    wr(8'h06, 2'b11, 16'hFFFF);
  endtask

  task automatic set_all();
    ev_addr_par = 1; ev_serr_sent = 1; cmd_serr_en = 1; ev_mst_abort = 1;
    ev_tgt_abort_rcvd = 1; ev_tgt_abort_sent = 1;
    ev_perr_seen = 1; bus_master_phase = 1; cmd_perr_en = 1;
    tick();
    ev_addr_par = 0; ev_serr_sent = 0; cmd_serr_en = 0; ev_mst_abort = 0;
    ev_tgt_abort_rcvd = 0; ev_tgt_abort_sent = 0;
    ev_perr_seen = 0; bus_master_phase = 0; cmd_perr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_wr_en = 0; cfg_rd_en = 0; cfg_offset = 8'h06; cfg_be = 0; cfg_wdata = 0;
    ev_addr_par = 0; ev_data_par = 0; ev_serr_sent = 0; ev_mst_abort = 0;
    ev_tgt_abort_rcvd = 0; ev_tgt_abort_sent = 0; ev_perr_seen = 0; bus_master_phase = 0;
    cmd_perr_en = 0; cmd_serr_en = 0; cmd_int_dis = 0; irq_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();

    // R1 reset value
    rd_chk("R1", FIX);
    chk("R1 int_pin", {15'd0, int_pin}, 16'h0000);

    // R2 read gating
    set_all();
    cfg_offset = 8'h04; #0.5; chk("R2 offset", cfg_rdata, 16'h0000);
    cfg_offset = 8'h06; cfg_rd_en = 0; #0.5; chk("R2 strobe", cfg_rdata, 16'h0000);
    clear_all();

    // R3 single events, one at a time
    for (int k = 0; k < 5; k++) begin
      logic [15:0] bitv;
      case (k)
        0: begin ev_addr_par = 1;       bitv = 16'h8000; end
        1: begin ev_data_par = 1;       bitv = 16'h8000; end
        2: begin ev_mst_abort = 1;      bitv = 16'h2000; end
        3: begin ev_tgt_abort_rcvd = 1; bitv = 16'h1000; end
        default: begin ev_tgt_abort_sent = 1; bitv = 16'h0800; end
      endcase
      tick();
      ev_addr_par = 0; ev_data_par = 0; ev_mst_abort = 0;
      ev_tgt_abort_rcvd = 0; ev_tgt_abort_sent = 0;
      rd_chk("R3", FIX | bitv);
      clear_all();
      rd_chk("R6 clear", FIX);
    end

    // R4 system-error qualifier sweep
    for (int k = 0; k < 4; k++) begin
      ev_serr_sent = k[0]; cmd_serr_en = k[1];
      tick();
      ev_serr_sent = 0; cmd_serr_en = 0;
      rd_chk("R4", FIX | ((k == 3) ? 16'h4000 : 16'h0000));
      clear_all();
    end

    // R5 data-parity three-way sweep
    for (int k = 0; k < 8; k++) begin
      ev_perr_seen = k[0]; bus_master_phase = k[1]; cmd_perr_en = k[2];
      tick();
      ev_perr_seen = 0; bus_master_phase = 0; cmd_perr_en = 0;
      rd_chk("R5", FIX | ((k == 7) ? 16'h0100 : 16'h0000));
      clear_all();
    end

    // R6 + R8 upper-lane data sweep, clear = written ones on sticky bits
    for (int d = 0; d < 256; d++) begin
      set_all();
      wr(8'h06, 2'b10, {d[7:0], 8'hFF});
      rd_chk("R6/R8", FIX | (STK & ~{d[7:0], 8'h00}));
    end

    // R6 lower lane only and wrong offset: no effect
    set_all();
    wr(8'h06, 2'b01, 16'hFFFF);
    rd_chk("R6 lane", FIX | STK);
    wr(8'h04, 2'b11, 16'hFFFF);
    rd_chk("R6 offset", FIX | STK);
    wr(8'h06, 2'b00, 16'hFFFF);
    rd_chk("R6 no-be", FIX | STK);

    // R11 hold through idle cycles
    repeat (20) tick();
    rd_chk("R11", FIX | STK);

    // R8 write all ones, fixed bits unaffected
    clear_all();
    wr(8'h06, 2'b11, 16'hFFFF);
    rd_chk("R8", FIX);

    // R7 set beats same-cycle clear, from clear and from set state
    for (int k = 0; k < 2; k++) begin
      if (k == 1) begin ev_mst_abort = 1; tick(); ev_mst_abort = 0; end
      ev_mst_abort = 1;
      cfg_wr_en = 1; cfg_offset = 8'h06; cfg_be = 2'b11; cfg_wdata = 16'h2000;
      tick();
      ev_mst_abort = 0; cfg_wr_en = 0;
      rd_chk("R7", FIX | 16'h2000);
      clear_all();
    end

    // R9 / R10 interrupt sweep
    for (int k = 0; k < 4; k++) begin
      irq_req = k[0]; cmd_int_dis = k[1];
      #0.5;
      rd_chk("R9", FIX | (k[0] ? 16'h0008 : 16'h0000));
      chk("R10", {15'd0, int_pin}, {15'd0, (k == 1)});
      tick();
    end
    irq_req = 0; cmd_int_dis = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule